// File: doc/BRIEF.md
# Deferred-Exception Poison Tracker

This block keeps one poison flag for each architectural general register, so that compiler-hoisted (speculative) instructions can put off fatal exceptions. Each retiring instruction presents its speculative marking, a store marking, up to two source register indices, an optional destination index, and an exception indication with a class (terminating or resumable). The block updates the flags and reports, one cycle later, whether the instruction must fault or trap.

A speculative instruction that hits a terminating exception does not stop the program. It marks its destination instead, and that mark spreads through later speculative consumers. The deferred error is raised only when a non-speculative instruction, or any store, reads a marked register. Resumable exceptions are always reported at once. For context switches, the whole flag vector can be saved in one request and restored in one write.

Top module: `poison_tracker`

## Requirements
- R1: After reset, every poison flag and the fault, trap and save-valid outputs are 0.
- R2: A speculative, non-store instruction with a terminating exception (`ret_exc_i`=1, `ret_exc_term_i`=1) sets the flag of its destination and raises no fault or trap.
- R3: A speculative, non-store instruction that reads a flagged source through either source port sets the flag of its destination and raises no fault.
- R4: A non-speculative instruction that reads a flagged source asserts `fault_o` for one cycle. `fault_src_o` gives the flagged index, and source port A wins when both are flagged. The flags stay unchanged, even when a destination is given.
- R5: A store is treated as non-speculative whatever its speculative input. It faults on a flagged source and never changes any flag.
- R6: A resumable exception (`ret_exc_term_i`=0) asserts `resume_trap_o` for one cycle for speculative and normal instructions alike, and leaves all flags unchanged.
- R7: A terminating exception on a non-speculative instruction with clean sources asserts `term_trap_o` for one cycle and leaves all flags unchanged.
- R8: An instruction that writes a destination with no poisoning cause clears that destination's flag, whether it is speculative or not.
- R9: Register 0 is never flagged, neither by retirement nor by restore.
- R10: A save request in a cycle with no retirement returns the full flag vector on `save_data_o`, with `save_valid_o`=1 in the next cycle. A save request during a retirement is ignored (`save_valid_o`=0).
- R11: A restore write in a cycle with no retirement loads the whole flag vector from `restore_data_i`. A restore write during a retirement is ignored.
- R12: Fault and trap outputs are one-cycle pulses, at most one of them is high, and none is high unless an instruction retired in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_spec_i | input | 1 | Retiring instruction is speculative |
| ret_store_i | input | 1 | Retiring instruction is a store |
| ret_src_a_valid_i | input | 1 | Source A is read |
| ret_src_a_i | input | 5 | Source A index |
| ret_src_b_valid_i | input | 1 | Source B is read |
| ret_src_b_i | input | 5 | Source B index |
| ret_dst_valid_i | input | 1 | Destination is written |
| ret_dst_i | input | 5 | Destination index |
| ret_exc_i | input | 1 | Instruction raised an exception |
| ret_exc_term_i | input | 1 | Exception class: 1 terminating, 0 resumable |
| save_req_i | input | 1 | Save request for the flag vector |
| restore_we_i | input | 1 | Restore write of the flag vector |
| restore_data_i | input | 32 | Vector to restore |
| fault_o | output | 1 | Deferred fault pulse |
| fault_src_o | output | 5 | Flagged source that caused the fault |
| term_trap_o | output | 1 | Immediate terminating-exception pulse |
| resume_trap_o | output | 1 | Resumable-exception pulse |
| save_valid_o | output | 1 | `save_data_o` holds a fresh snapshot |
| save_data_o | output | 32 | Saved flag vector |
| poison_o | output | 32 | Live flag vector |

## Verification
The bench builds a chain in which a deferred error passes through two speculative consumers, one reached through source B, and then checks that a normal reader faults on the right index. A design that tested only port A, or let the destination write win over the fault, would show a wrong `fault_src_o` or a changed vector. Stores with the speculative input set must still fault, and a design that trusted that input would stay silent. Resumable exceptions on speculative instructions must trap and leave flags alone, and a design that deferred them would set a flag instead. Save and restore requests are issued both alone and together with a retirement, so a design that ignored the collision rule would lose an update or report a stale snapshot. Register 0 is targeted both through poisoning and through an all-ones restore.

// File: rtl/poison_pkg.sv
package poison_pkg;
  typedef enum logic [2:0] {
    OUT_NONE,
    OUT_FAULT,
    OUT_TERM,
    OUT_RESUME,
    OUT_UPDATE
  } outcome_e;
endpackage

// File: rtl/poison_src_check.sv
module poison_src_check #(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]           poison_i,
  input  logic [NUM_SRC-1:0]            src_valid_i,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx_i,
  output logic                          any_poison_o,
  output logic [IDX_W-1:0]              first_idx_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign hit[k] = src_valid_i[k] & poison_i[src_idx_i[k]];
  end

  assign any_poison_o = |hit;

  // lowest port number wins
  always_comb begin
    first_idx_o = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (hit[k]) first_idx_o = src_idx_i[k];
    end
  end
endmodule

// File: rtl/poison_classify.sv
module poison_classify
  import poison_pkg::*;
(
  input  logic     valid_i,
  input  logic     spec_i,
  input  logic     store_i,
  input  logic     dst_valid_i,
  input  logic     src_poison_i,
  input  logic     exc_i,
  input  logic     exc_term_i,
  output outcome_e outcome_o,
  output logic     dst_we_o,
  output logic     dst_val_o
);
  logic normal;
  assign normal = ~spec_i | store_i;

  always_comb begin
    outcome_o = OUT_NONE;
    dst_we_o  = 1'b0;
    dst_val_o = 1'b0;
    if (valid_i) begin
      if (normal && src_poison_i) begin
        outcome_o = OUT_FAULT;
      end else if (exc_i && !exc_term_i) begin
        outcome_o = OUT_RESUME;
      end else if (exc_i && normal) begin
        outcome_o = OUT_TERM;
      end else begin
        outcome_o = OUT_UPDATE;
        dst_we_o  = dst_valid_i & ~store_i;
        dst_val_o = ~normal & (src_poison_i | exc_i);
      end
    end
  end
endmodule

// File: rtl/poison_bits.sv
module poison_bits #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_en_i,
  input  logic [IDX_W-1:0]    upd_idx_i,
  input  logic                upd_val_i,
  input  logic                load_en_i,
  input  logic [NUM_REGS-1:0] load_data_i,
  output logic [NUM_REGS-1:0] bits_o
);
  assign bits_o[0] = 1'b0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= 1'b0;
      end else if (load_en_i) begin
        q <= load_data_i[i];
      end else if (upd_en_i && upd_idx_i == IDX_W'(i)) begin
        q <= upd_val_i;
      end
    end
    assign bits_o[i] = q;
  end
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ret_valid_i,
  input  logic                ret_spec_i,
  input  logic                ret_store_i,
  input  logic                ret_src_a_valid_i,
  input  logic [IDX_W-1:0]    ret_src_a_i,
  input  logic                ret_src_b_valid_i,
  input  logic [IDX_W-1:0]    ret_src_b_i,
  input  logic                ret_dst_valid_i,
  input  logic [IDX_W-1:0]    ret_dst_i,
  input  logic                ret_exc_i,
  input  logic                ret_exc_term_i,
  input  logic                save_req_i,
  input  logic                restore_we_i,
  input  logic [NUM_REGS-1:0] restore_data_i,
  output logic                fault_o,
  output logic [IDX_W-1:0]    fault_src_o,
  output logic                term_trap_o,
  output logic                resume_trap_o,
  output logic                save_valid_o,
  output logic [NUM_REGS-1:0] save_data_o,
  output logic [NUM_REGS-1:0] poison_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_REGS-1:0]           bits;
  logic [NUM_SRC-1:0]            src_valid;
  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
  logic                          src_poison;
  logic [IDX_W-1:0]              src_first;
  outcome_e                      outcome;
  logic                          dst_we;
  logic                          dst_val;
  logic                          ctx_load;
  logic                          ctx_save;

  assign src_valid = {ret_src_b_valid_i, ret_src_a_valid_i};
  assign src_idx   = {ret_src_b_i, ret_src_a_i};

  poison_src_check #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)) u_src (
    .poison_i     (bits),
    .src_valid_i  (src_valid),
    .src_idx_i    (src_idx),
    .any_poison_o (src_poison),
    .first_idx_o  (src_first)
  );

  poison_classify u_cls (
    .valid_i      (ret_valid_i),
    .spec_i       (ret_spec_i),
    .store_i      (ret_store_i),
    .dst_valid_i  (ret_dst_valid_i),
    .src_poison_i (src_poison),
    .exc_i        (ret_exc_i),
    .exc_term_i   (ret_exc_term_i),
    .outcome_o    (outcome),
    .dst_we_o     (dst_we),
    .dst_val_o    (dst_val)
  );

  // context access yields to retirement
  assign ctx_load = restore_we_i & ~ret_valid_i;
  assign ctx_save = save_req_i & ~ret_valid_i;

  poison_bits #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_en_i    (dst_we),
    .upd_idx_i   (ret_dst_i),
    .upd_val_i   (dst_val),
    .load_en_i   (ctx_load),
    .load_data_i (restore_data_i),
    .bits_o      (bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o       <= 1'b0;
      fault_src_o   <= '0;
      term_trap_o   <= 1'b0;
      resume_trap_o <= 1'b0;
    end else begin
      fault_o       <= (outcome == OUT_FAULT);
      term_trap_o   <= (outcome == OUT_TERM);
      resume_trap_o <= (outcome == OUT_RESUME);
      if (outcome == OUT_FAULT) fault_src_o <= src_first;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      save_valid_o <= 1'b0;
      save_data_o  <= '0;
    end else begin
      save_valid_o <= ctx_save;
      if (ctx_save) save_data_o <= bits;
    end
  end

  assign poison_o = bits;
endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int NUM_REGS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ret_valid_i,
  input logic                save_req_i,
  input logic                fault_o,
  input logic                term_trap_o,
  input logic                resume_trap_o,
  input logic                save_valid_o,
  input logic [NUM_REGS-1:0] poison_o
);
  // R9
  reg0_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poison_o[0] == 1'b0);

  // R4
  fault_keeps_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> poison_o == $past(poison_o));

  // R6
  resume_keeps_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_trap_o |-> poison_o == $past(poison_o));

  // R7
  term_keeps_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_trap_o |-> poison_o == $past(poison_o));

  // R12
  pulse_needs_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o || term_trap_o || resume_trap_o) |-> $past(ret_valid_i));

  // R12
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_o, term_trap_o, resume_trap_o}));

  // R10
  save_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_valid_o |-> $past(save_req_i && !ret_valid_i));
endmodule

bind poison_tracker poison_tracker_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ret_valid_i   (ret_valid_i),
  .save_req_i    (save_req_i),
  .fault_o       (fault_o),
  .term_trap_o   (term_trap_o),
  .resume_trap_o (resume_trap_o),
  .save_valid_o  (save_valid_o),
  .poison_o      (poison_o)
);

// File: tb/poison_tracker_tb.sv
module poison_tracker_tb;
  localparam int NR    = 32;
  localparam int IDX_W = $clog2(NR);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ret_valid_i = 0, ret_spec_i = 0, ret_store_i = 0;
  logic ret_src_a_valid_i = 0, ret_src_b_valid_i = 0, ret_dst_valid_i = 0;
  logic [IDX_W-1:0] ret_src_a_i = '0, ret_src_b_i = '0, ret_dst_i = '0;
  logic ret_exc_i = 0, ret_exc_term_i = 0;
  logic save_req_i = 0, restore_we_i = 0;
  logic [NR-1:0] restore_data_i = '0;
  logic fault_o, term_trap_o, resume_trap_o, save_valid_o;
  logic [IDX_W-1:0] fault_src_o;
  logic [NR-1:0] save_data_o, poison_o;

  int n_chk = 0;
  int n_err = 0;
  logic [NR-1:0] exp_p = '0;

  always #10 clk_i = ~clk_i;

  poison_tracker #(.NUM_REGS(NR)) u_dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic retire(input logic spec, input logic store,
                        input logic av, input int a, input logic bv, input int b,
                        input logic dv, input int d, input logic exc, input logic term);
    @(negedge clk_i);
    ret_valid_i = 1; ret_spec_i = spec; ret_store_i = store;
    ret_src_a_valid_i = av; ret_src_a_i = a[IDX_W-1:0];
    ret_src_b_valid_i = bv; ret_src_b_i = b[IDX_W-1:0];
    ret_dst_valid_i = dv; ret_dst_i = d[IDX_W-1:0];
    ret_exc_i = exc; ret_exc_term_i = term;
    @(posedge clk_i); #1;
    ret_valid_i = 0; ret_spec_i = 0; ret_store_i = 0;
    ret_src_a_valid_i = 0; ret_src_b_valid_i = 0; ret_dst_valid_i = 0;
    ret_exc_i = 0; ret_exc_term_i = 0;
  endtask

  task automatic outs(input string req, input logic f, input logic t, input logic r);
    chk(req, "fault_o", 32'(fault_o), 32'(f));
    chk(req, "term_trap_o", 32'(term_trap_o), 32'(t));
    chk(req, "resume_trap_o", 32'(resume_trap_o), 32'(r));
    chk(req, "poison_o", poison_o, exp_p);
  endtask

  task automatic t_reset;
    chk("R1", "poison_o", poison_o, '0);
    chk("R1", "save_valid_o", 32'(save_valid_o), 0);
    outs("R1", 0, 0, 0);
  endtask

  task automatic t_spec_term;
    retire(1, 0, 0, 0, 0, 0, 1, 5, 1, 1);
    exp_p[5] = 1'b1;
    outs("R2", 0, 0, 0);
  endtask

  task automatic t_propagate;
    retire(1, 0, 1, 5, 0, 0, 1, 7, 0, 0);
    exp_p[7] = 1'b1;
    outs("R3", 0, 0, 0);
    retire(1, 0, 1, 2, 1, 7, 1, 9, 0, 0);
    exp_p[9] = 1'b1;
    outs("R3", 0, 0, 0);
  endtask

  task automatic t_normal_fault;
    retire(0, 0, 1, 3, 1, 9, 1, 12, 0, 0);
    outs("R4", 1, 0, 0);
    chk("R4", "fault_src_o", 32'(fault_src_o), 9);
    retire(0, 0, 1, 5, 1, 7, 1, 7, 0, 0);
    outs("R4", 1, 0, 0);
    chk("R4", "fault_src_o", 32'(fault_src_o), 5);
  endtask

  task automatic t_store;
    retire(1, 1, 1, 7, 0, 0, 0, 0, 0, 0);
    outs("R5", 1, 0, 0);
    chk("R5", "fault_src_o", 32'(fault_src_o), 7);
    retire(1, 1, 1, 2, 0, 0, 1, 5, 0, 0);
    outs("R5", 0, 0, 0);
  endtask

  task automatic t_resume;
    retire(1, 0, 0, 0, 0, 0, 1, 11, 1, 0);
    outs("R6", 0, 0, 1);
    retire(0, 0, 1, 2, 0, 0, 1, 9, 1, 0);
    outs("R6", 0, 0, 1);
  endtask

  task automatic t_term;
    retire(0, 0, 1, 2, 0, 0, 1, 9, 1, 1);
    outs("R7", 0, 1, 0);
  endtask

  task automatic t_clear;
    retire(0, 0, 1, 2, 0, 0, 1, 5, 0, 0);
    exp_p[5] = 1'b0;
    outs("R8", 0, 0, 0);
    retire(1, 0, 0, 0, 0, 0, 1, 7, 0, 0);
    exp_p[7] = 1'b0;
    outs("R8", 0, 0, 0);
  endtask

  task automatic t_reg0;
    retire(1, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    outs("R9", 0, 0, 0);
    @(negedge clk_i);
    restore_we_i = 1; restore_data_i = '1;
    @(posedge clk_i); #1;
    restore_we_i = 0;
    exp_p = ~NR'(1);
    chk("R9", "poison_o", poison_o, exp_p);
  endtask

  task automatic t_save;
    @(negedge clk_i);
    save_req_i = 1;
    @(posedge clk_i); #1;
    save_req_i = 0;
    chk("R10", "save_valid_o", 32'(save_valid_o), 1);
    chk("R10", "save_data_o", save_data_o, exp_p);
    @(negedge clk_i);
    save_req_i = 1;
    ret_valid_i = 1; ret_src_a_valid_i = 0; ret_dst_valid_i = 1; ret_dst_i = 3;
    @(posedge clk_i); #1;
    save_req_i = 0; ret_valid_i = 0; ret_dst_valid_i = 0;
    exp_p[3] = 1'b0;
    chk("R10", "save_valid_o", 32'(save_valid_o), 0);
    chk("R10", "poison_o", poison_o, exp_p);
  endtask

  task automatic t_restore;
    @(negedge clk_i);
    restore_we_i = 1; restore_data_i = '0;
    ret_valid_i = 1; ret_dst_valid_i = 1; ret_dst_i = 4;
    @(posedge clk_i); #1;
    restore_we_i = 0; ret_valid_i = 0; ret_dst_valid_i = 0;
    exp_p[4] = 1'b0;
    chk("R11", "poison_o", poison_o, exp_p);
    @(negedge clk_i);
    restore_we_i = 1; restore_data_i = 32'h0000_00F0;
    @(posedge clk_i); #1;
    restore_we_i = 0;
    exp_p = 32'h0000_00F0;
    chk("R11", "poison_o", poison_o, exp_p);
  endtask

  task automatic t_pulse;
    retire(0, 0, 1, 4, 0, 0, 0, 0, 0, 0);
    outs("R12", 1, 0, 0);
    @(posedge clk_i); #1;
    outs("R12", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_spec_term();
    t_propagate();
    t_normal_fault();
    t_store();
    t_resume();
    t_term();
    t_clear();
    t_reg0();
    t_save();
    t_restore();
    t_pulse();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule